// File: doc/BRIEF.md
# Cascadable Paired Timer Counter

Two 16-bit counter channels sit side by side. Each one can run on its own, or the pair can be joined into one 32-bit counter. The lower channel holds the low half and the upper channel holds the high half. A channel counts in one of two ways:

- from a tap of a shared free-running prescaler, selected by a 3-bit clock-select field;
- in phase counting mode, from a pair of two-phase quadrature inputs, which lets it count either up or down.

On the upper channel, clock-select code 7 chains the pair. In that setting the upper channel takes its count events from the lower channel's wraps and not from a clock. Each wrap of the lower channel moves the upper channel on the same clock edge, so the combined 32-bit value is never seen half-updated.

Each channel has its own start bit. Software can load either half at any time, and a load wins over any count event in the same cycle. The block exposes both halves and their concatenation for reading.

Top module: `ptc_cascade_timer`

## Requirements
- R1: `full_count` always equals `{hi_count, lo_count}`, with the upper channel in bits 31:16 and the lower channel in bits 15:0.
- R2: Clock-select codes select the count rate as follows:
  - codes 0, 1, 2 and 3 count once every 1, 4, 16 and 64 clock cycles;
  - codes 4, 5 and 6 do not count;
  - code 7 on the lower channel does not count.
- R3: With `hi_clksel` = 7 and `hi_phase_mode` = 0, the upper counter adds one on every lower wrap from 16'hFFFF to 16'h0000. It does so at the same clock edge as the lower wrap.
- R4: In the chained setting, the upper counter subtracts one on every lower wrap from 16'h0000 to 16'hFFFF. Such a down wrap can only happen while the lower channel is in phase counting mode.
- R5: When `hi_phase_mode` = 1, the upper channel ignores `hi_clksel` and any lower wraps, and counts only from its own quadrature inputs.
- R6: Phase counting behaves as follows:
  - The inputs pass through 2-flop synchronizers, and the counter moves once per single-bit change of the pair {A,B}.
  - The sequence 00→10→11→01→00 counts up.
  - The reverse sequence counts down.
  - A change of both bits at once is ignored.
- R7: A channel whose start bit is 0 holds its value and ignores every count event, including wraps coming from its partner.
- R8: A write to a channel loads `*_wr_data` on the next edge and takes priority over counting. A write never produces a wrap event.
- R9: An asynchronous active-low reset clears both counters to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_start | input | 1 | Run enable, lower channel |
| hi_start | input | 1 | Run enable, upper channel |
| lo_phase_mode | input | 1 | Lower channel counts quadrature inputs |
| hi_phase_mode | input | 1 | Upper channel counts quadrature inputs |
| lo_clksel | input | 3 | Lower clock select |
| hi_clksel | input | 3 | Upper clock select, 7 = chain |
| lo_pha | input | 1 | Lower quadrature phase A |
| lo_phb | input | 1 | Lower quadrature phase B |
| hi_pha | input | 1 | Upper quadrature phase A |
| hi_phb | input | 1 | Upper quadrature phase B |
| lo_wr_en | input | 1 | Load strobe, lower counter |
| lo_wr_data | input | 16 | Load value, lower counter |
| hi_wr_en | input | 1 | Load strobe, upper counter |
| hi_wr_data | input | 16 | Load value, upper counter |
| lo_count | output | 16 | Lower counter value |
| hi_count | output | 16 | Upper counter value |
| full_count | output | 32 | Combined 32-bit value |

## Verification
The bench targets four corner cases:

- **The carry edge from 16'h0FFFF.** A design that carries one cycle late would show a torn value such as 32'h0005_0000.
- **The borrow from 16'h0000 under quadrature.** A design that only ever increments the upper half would miss it.
- **Loading 16'h1234 over a lower half that is about to wrap.** A design that lets the write leak a carry would bump the upper half.
- **Conditions that must have no effect.** These are:
  - a stopped upper half during a lower wrap;
  - an upper half in phase counting mode while chained;
  - a simultaneous change on both quadrature inputs.

A design that got any of these wrong would show a changed 32-bit value where the bench expects none.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
   localparam int CSEL_W = 3;
   localparam logic [CSEL_W-1:0] CS_CHAIN = 3'd7;
   localparam int DEF_TAPS = 4;
   localparam int DEF_TAP_SHIFT = 2;
endpackage

// File: rtl/ptc_prescaler.sv
module ptc_prescaler #(
   parameter int N_TAPS    = 4,
   parameter int TAP_SHIFT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [N_TAPS-1:0] tick
);
   localparam int PW = (N_TAPS - 1) * TAP_SHIFT;

   logic [PW-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
      if (k == 0) begin : g_full
         assign tick[k] = 1'b1;
      end else begin : g_div
         assign tick[k] = &div_q[k*TAP_SHIFT-1:0];
      end
   end

   // R2: the slowest tap fires exactly when the divider returns to zero next
   a_r2_slow_tap_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      tick[N_TAPS-1] |=> (div_q == '0));
endmodule

// File: rtl/ptc_quad.sv
module ptc_quad #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pha,
   input  logic phb,
   output logic step_up,
   output logic step_dn
);
   logic [SYNC_STAGES-1:0] sa_q, sb_q;
   logic [1:0] cur, prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sa_q   <= '0;
         sb_q   <= '0;
         prev_q <= 2'b00;
      end else begin
         sa_q   <= {sa_q[SYNC_STAGES-2:0], pha};
         sb_q   <= {sb_q[SYNC_STAGES-2:0], phb};
         prev_q <= cur;
      end
   end

   assign cur = {sa_q[SYNC_STAGES-1], sb_q[SYNC_STAGES-1]};

   always_comb begin
      step_up = 1'b0;
      step_dn = 1'b0;
      case ({prev_q, cur})
         4'b0010, 4'b1011, 4'b1101, 4'b0100: step_up = 1'b1;
         4'b0001, 4'b0111, 4'b1110, 4'b1000: step_dn = 1'b1;
         default: ;
      endcase
   end

   // R6: a step requires that the synchronized pair changed since last cycle
   a_r6_step_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up || step_dn) |-> (cur != $past(cur)));
endmodule

// File: rtl/ptc_channel.sv
module ptc_channel
   import ptc_pkg::*;
#(
   parameter int W        = 16,
   parameter int N_TAPS   = 4,
   parameter bit CHAIN_EN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              phase_mode,
   input  logic [CSEL_W-1:0] csel,
   input  logic [N_TAPS-1:0] tick,
   input  logic              q_up,
   input  logic              q_dn,
   input  logic              chain_up,
   input  logic              chain_dn,
   input  logic              wr_en,
   input  logic [W-1:0]      wr_data,
   output logic [W-1:0]      cnt,
   output logic              wrap_up,
   output logic              wrap_dn
);
   localparam logic [W-1:0] CNT_MAX = '1;

   logic inc, dec;

   always_comb begin
      inc = 1'b0;
      dec = 1'b0;
      if (phase_mode) begin
         inc = q_up;
         dec = q_dn;
      end else if (csel == CS_CHAIN) begin
         inc = CHAIN_EN ? chain_up : 1'b0;
         dec = CHAIN_EN ? chain_dn : 1'b0;
      end else begin
         for (int k = 0; k < N_TAPS; k++) begin
            if (csel == CSEL_W'(k)) inc = tick[k];
         end
      end
      if (!start || wr_en) begin
         inc = 1'b0;
         dec = 1'b0;
      end
   end

   assign wrap_up = inc && (cnt == CNT_MAX);
   assign wrap_dn = dec && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (wr_en) cnt <= wr_data;
      else if (inc)   cnt <= cnt + 1'b1;
      else if (dec)   cnt <= cnt - 1'b1;
   end

   a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cnt == $past(wr_data)));
   a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !wr_en) |=> $stable(cnt));
   a_r3_wrap_up_lands_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_up |=> (cnt == '0));
   a_r4_wrap_dn_lands_max: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_dn |=> (cnt == CNT_MAX));
endmodule

// File: rtl/ptc_cascade_timer.sv
module ptc_cascade_timer
   import ptc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int N_TAPS      = DEF_TAPS,
   parameter int TAP_SHIFT   = DEF_TAP_SHIFT,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lo_start,
   input  logic                hi_start,
   input  logic                lo_phase_mode,
   input  logic                hi_phase_mode,
   input  logic [CSEL_W-1:0]   lo_clksel,
   input  logic [CSEL_W-1:0]   hi_clksel,
   input  logic                lo_pha,
   input  logic                lo_phb,
   input  logic                hi_pha,
   input  logic                hi_phb,
   input  logic                lo_wr_en,
   input  logic [CNT_W-1:0]    lo_wr_data,
   input  logic                hi_wr_en,
   input  logic [CNT_W-1:0]    hi_wr_data,
   output logic [CNT_W-1:0]    lo_count,
   output logic [CNT_W-1:0]    hi_count,
   output logic [2*CNT_W-1:0]  full_count
);
   if (CNT_W < 2) begin : g_bad_w
      $error("CNT_W must be at least 2");
   end
   if (N_TAPS < 2 || N_TAPS > 7) begin : g_bad_taps
      $error("N_TAPS must lie in 2..7 so the chain code stays free");
   end
   if (TAP_SHIFT < 1) begin : g_bad_shift
      $error("TAP_SHIFT must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [N_TAPS-1:0] tick;
   logic lo_qu, lo_qd, hi_qu, hi_qd;
   logic lo_wu, lo_wd, hi_wu, hi_wd;

   ptc_prescaler #(.N_TAPS(N_TAPS), .TAP_SHIFT(TAP_SHIFT)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   ptc_quad #(.SYNC_STAGES(SYNC_STAGES)) u_lo_q (
      .clk(clk), .rst_n(rst_n), .pha(lo_pha), .phb(lo_phb),
      .step_up(lo_qu), .step_dn(lo_qd));

   ptc_quad #(.SYNC_STAGES(SYNC_STAGES)) u_hi_q (
      .clk(clk), .rst_n(rst_n), .pha(hi_pha), .phb(hi_phb),
      .step_up(hi_qu), .step_dn(hi_qd));

   ptc_channel #(.W(CNT_W), .N_TAPS(N_TAPS), .CHAIN_EN(1'b0)) u_lo (
      .clk(clk), .rst_n(rst_n), .start(lo_start), .phase_mode(lo_phase_mode),
      .csel(lo_clksel), .tick(tick), .q_up(lo_qu), .q_dn(lo_qd),
      .chain_up(1'b0), .chain_dn(1'b0),
      .wr_en(lo_wr_en), .wr_data(lo_wr_data), .cnt(lo_count),
      .wrap_up(lo_wu), .wrap_dn(lo_wd));

   ptc_channel #(.W(CNT_W), .N_TAPS(N_TAPS), .CHAIN_EN(1'b1)) u_hi (
      .clk(clk), .rst_n(rst_n), .start(hi_start), .phase_mode(hi_phase_mode),
      .csel(hi_clksel), .tick(tick), .q_up(hi_qu), .q_dn(hi_qd),
      .chain_up(lo_wu), .chain_dn(lo_wd),
      .wr_en(hi_wr_en), .wr_data(hi_wr_data), .cnt(hi_count),
      .wrap_up(hi_wu), .wrap_dn(hi_wd));

   assign full_count = {hi_count, lo_count};

   logic chained;
   assign chained = (hi_clksel == CS_CHAIN) && !hi_phase_mode && hi_start && !hi_wr_en;

   a_r3_chain_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (chained && lo_wu) |=> (hi_count == CNT_W'($past(hi_count) + 1'b1)));
   a_r4_chain_borrow: assert property (@(posedge clk) disable iff (!rst_n)
      (chained && lo_wd) |=> (hi_count == CNT_W'($past(hi_count) - 1'b1)));
   a_r4_no_borrow_counting_up: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_phase_mode |-> !lo_wd);
   a_r5_phase_blocks_chain: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_phase_mode && !hi_wr_en && !hi_qu && !hi_qd) |=> $stable(hi_count));
   a_r1_wrap_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_wu && hi_wd));
endmodule

// File: tb/tb_ptc_cascade_timer.sv
`timescale 1ns/1ps
module tb_ptc_cascade_timer;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lo_start = 0, hi_start = 0, lo_phase_mode = 0, hi_phase_mode = 0;
   logic [2:0] lo_clksel = 0, hi_clksel = 0;
   logic lo_pha = 0, lo_phb = 0, hi_pha = 0, hi_phb = 0;
   logic lo_wr_en = 0, hi_wr_en = 0;
   logic [15:0] lo_wr_data = 0, hi_wr_data = 0;
   logic [15:0] lo_count, hi_count;
   logic [31:0] full_count;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   ptc_cascade_timer dut (
      .clk(clk), .rst_n(rst_n), .lo_start(lo_start), .hi_start(hi_start),
      .lo_phase_mode(lo_phase_mode), .hi_phase_mode(hi_phase_mode),
      .lo_clksel(lo_clksel), .hi_clksel(hi_clksel),
      .lo_pha(lo_pha), .lo_phb(lo_phb), .hi_pha(hi_pha), .hi_phb(hi_phb),
      .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
      .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
      .lo_count(lo_count), .hi_count(hi_count), .full_count(full_count));

   typedef struct packed {
      logic [2:0]  cs;
      logic [15:0] cycles;
      logic [15:0] delta;
   } rate_vec_t;

   localparam int NVEC = 8;
   localparam rate_vec_t VEC [NVEC] = '{
      '{3'd0, 16'd10,  16'd10},
      '{3'd1, 16'd64,  16'd16},
      '{3'd2, 16'd64,  16'd4},
      '{3'd3, 16'd128, 16'd2},
      '{3'd4, 16'd20,  16'd0},
      '{3'd5, 16'd20,  16'd0},
      '{3'd6, 16'd20,  16'd0},
      '{3'd7, 16'd20,  16'd0}
   };

   task automatic step(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load(logic [15:0] hv, logic [15:0] lv);
      hi_wr_en = 1; hi_wr_data = hv;
      lo_wr_en = 1; lo_wr_data = lv;
      step();
      hi_wr_en = 0; lo_wr_en = 0;
   endtask

   task automatic lo_phase(logic a, logic b);
      lo_pha = a; lo_phb = b;
      step(5);
   endtask

   initial begin
      #(200000 * 4);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      step(3);
      chk("R9 reset clears", full_count, 32'h0);
      rst_n = 1;
      step();
      chk("R1 concat", full_count, {hi_count, lo_count});

      // R2 rate table
      for (int i = 0; i < NVEC; i++) begin
         lo_clksel = VEC[i].cs;
         load(16'h0, 16'h0);
         lo_start = 1;
         step(int'(VEC[i].cycles));
         lo_start = 0;
         step();
         chk($sformatf("R2 clksel %0d", VEC[i].cs), {16'h0, lo_count},
             {16'h0, VEC[i].delta});
      end

      // R3 chained carry, coherent 32-bit value
      lo_clksel = 3'd0; hi_clksel = 3'd7;
      load(16'h0005, 16'hFFFE);
      lo_start = 1; hi_start = 1;
      step();
      chk("R3 before wrap", full_count, 32'h0005_FFFF);
      step();
      lo_start = 0; hi_start = 0;
      chk("R3 carry same edge", full_count, 32'h0006_0000);
      chk("R1 halves", {hi_count, lo_count}, 32'h0006_0000);

      // R7 stopped upper ignores lower wrap
      load(16'h0009, 16'hFFFF);
      lo_start = 1;
      step();
      lo_start = 0;
      chk("R7 upper halted", full_count, 32'h0009_0000);

      // R7 stopped lower holds
      load(16'h0009, 16'hFFFF);
      hi_start = 1;
      step(3);
      hi_start = 0;
      chk("R7 lower halted", full_count, 32'h0009_FFFF);

      // R8 write beats count, no carry
      lo_start = 1; hi_start = 1;
      lo_wr_en = 1; lo_wr_data = 16'h1234;
      step();
      lo_wr_en = 0; lo_start = 0; hi_start = 0;
      chk("R8 write priority", full_count, 32'h0009_1234);

      // R5 upper phase mode overrides chaining
      hi_phase_mode = 1;
      load(16'h0009, 16'hFFFF);
      lo_start = 1; hi_start = 1;
      step();
      lo_start = 0;
      chk("R5 chain ignored", full_count, 32'h0009_0000);
      hi_pha = 1;
      step(5);
      hi_start = 0;
      chk("R5 own quadrature", full_count, 32'h000A_0000);
      hi_phase_mode = 0;

      // R4 borrow through quadrature
      lo_phase_mode = 1;
      load(16'h0020, 16'h0000);
      lo_start = 1; hi_start = 1;
      lo_phase(1'b0, 1'b1);
      chk("R4 borrow", full_count, 32'h001F_FFFF);
      lo_phase(1'b0, 1'b0);
      chk("R3 carry from quadrature", full_count, 32'h0020_0000);

      // R6 full up cycle then full down cycle
      lo_phase(1'b1, 1'b0);
      lo_phase(1'b1, 1'b1);
      lo_phase(1'b0, 1'b1);
      lo_phase(1'b0, 1'b0);
      chk("R6 up sequence", full_count, 32'h0020_0004);
      lo_phase(1'b0, 1'b1);
      lo_phase(1'b1, 1'b1);
      lo_phase(1'b1, 1'b0);
      lo_phase(1'b0, 1'b0);
      chk("R6 down sequence", full_count, 32'h0020_0000);

      // R6 double transition ignored
      lo_phase(1'b1, 1'b1);
      chk("R6 double ignored", full_count, 32'h0020_0000);
      lo_phase(1'b0, 1'b0);
      chk("R6 double back ignored", full_count, 32'h0020_0000);
      lo_start = 0; hi_start = 0;

      // R9 reset mid-run
      rst_n = 0;
      step();
      chk("R9 reset mid-run", full_count, 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule